// File: doc/BRIEF.md
# Tag-Broadcast Issue and Wakeup Unit

This block takes instructions in program order and places each one in a free reservation station of the right class: stations for add and subtract, or stations for multiply and divide. At issue, every source register is looked up in a register result status table. If no instruction in flight will write that register, the station records the register's value. Otherwise it records the tag of the station that will produce it. The issuing station's tag then becomes the pending producer of the destination register. Register names therefore turn into producer tags at issue, which removes write-after-read and write-after-write conflicts between instructions in flight.

Each station has its own countdown unit with a fixed latency per operation. A station starts counting only when both of its operands hold values. A finished station drives a single result bus with its tag and its data. Every waiting station whose source tag matches takes the data. The register whose status entry matches is written and its status entry is cleared, and the producing station becomes free. Only one result goes on the bus per cycle. When several stations finish together, the lowest tag goes first and the others keep their results. An instruction that issues in the same cycle its producer broadcasts takes the value straight from the bus.

An observation port reads one architectural register and its pending tag. This port lets the register file be checked from outside the block.

Top module: `rsv_core`

## Requirements
- R1: After reset no result is broadcast (`cdb_valid`=0), every register r holds the value r, every status entry reads tag 0, and issue is accepted for both classes.
- R2: Operation codes are 0=add, 1=subtract, 2=multiply, 3=divide; bit 1 selects the multiply/divide class. `iss_ready` is high exactly when the class of `iss_op` has a free station. An instruction is accepted on a rising edge with `iss_valid` and `iss_ready` both high, and issue stalls otherwise.
- R3: Tag 0 means "no producer". Add stations carry tags 1..N_ADD and multiply stations carry tags N_ADD+1..N_ADD+N_MUL. Issue always takes the lowest free station of its class.
- R4: At issue, a source whose status entry is 0 takes the register value. A source with a pending producer records that producer's tag and waits for it.
- R5: After the accepting edge, the status entry of the destination holds the issuing station's tag.
- R6: A station starts its countdown only when both operands are values. Latencies are 3 cycles for add and subtract, 10 for multiply and 40 for divide. An instruction whose operands are ready at issue, and that wins the bus, appears on it after rising edge k+L+1, where k is the accepting edge and L the latency.
- R7: Add, subtract and multiply give results modulo 2^64. Divide gives the unsigned quotient, and divide by zero gives all ones.
- R8: A waiting station takes the bus data for each operand whose tag matches the broadcast tag. A consumer that waits only on producer P reaches the bus L+2 cycles after P does.
- R9: On the edge that ends a broadcast, the register whose status entry equals the tag is written with the data and its entry returns to 0, and the producing station becomes free.
- R10: At most one result is on the bus per cycle. The lowest finished tag wins, and a losing station holds its result until it is granted.
- R11: An instruction that issues during the cycle in which its source's producer broadcasts takes the broadcast value and does not wait for that tag.
- R12: When a later instruction takes over a destination's status entry, an earlier producer's broadcast does not write that register.
- R13: Subtract computes src1 - src2 and divide computes src1 / src2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Head of the op queue holds an instruction |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | A station of the requested class is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 4 | Tag of the producing station |
| cdb_data | output | 64 | Result value |
| obs_reg | input | 3 | Register selected for observation |
| obs_value | output | 64 | Value of the selected register |
| obs_tag | output | 4 | Pending producer tag of the selected register, 0 if none |

## Verification
On every cycle the assertions check the bus rules. A broadcast tag is never 0 and always names a real station. No finished station with a lower tag is passed over, the bus is never idle while a result waits, and a losing station keeps its request. Each accepted issue fills exactly one station, a stalled cycle fills none, and the broadcasting station is free afterwards. Only the bench scenarios can show the data path. These scenarios cover the latencies per operation, the arithmetic and operand order, the wakeup delay after a producer, the same-cycle bypass, and a register that keeps its newer value when an older writer finishes late.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rsv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } rsv_st_e;
endpackage

// File: rtl/rsv_station.sv
module rsv_station
  import rsv_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 6,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  rsv_op_e           op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [DATA_W-1:0] result_o
);
  rsv_st_e           st_q, st_d;
  rsv_op_e           op_q, op_d;
  logic [DATA_W-1:0] vj_q, vj_d, vk_q, vk_d;
  logic [TAG_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lat_sel;
  logic              pay_en, cnt_en;

  always_comb begin
    unique case (op_q)
      OP_MUL:  lat_sel = CNT_W'(LAT_MUL);
      OP_DIV:  lat_sel = CNT_W'(LAT_DIV);
      default: lat_sel = CNT_W'(LAT_ADD);
    endcase
  end

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    vj_d   = vj_q;
    qj_d   = qj_q;
    vk_d   = vk_q;
    qk_d   = qk_q;
    cnt_d  = cnt_q;
    pay_en = 1'b0;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (alloc_i) begin
          st_d   = ST_WAIT;
          op_d   = op_i;
          vj_d   = vj_i;
          qj_d   = qj_i;
          vk_d   = vk_i;
          qk_d   = qk_i;
          pay_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (qj_q == '0 && qk_q == '0) begin
          st_d   = ST_EXEC;
          cnt_d  = lat_sel;
          cnt_en = 1'b1;
        end else if (cdb_valid_i) begin
          if (qj_q != '0 && qj_q == cdb_tag_i) begin
            vj_d   = cdb_data_i;
            qj_d   = '0;
            pay_en = 1'b1;
          end
          if (qk_q != '0 && qk_q == cdb_tag_i) begin
            vk_d   = cdb_data_i;
            qk_d   = '0;
            pay_en = 1'b1;
          end
        end
      end
      ST_EXEC: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_W'(1)) st_d = ST_DONE;
        else                    cnt_d = cnt_q - CNT_W'(1);
      end
      ST_DONE: begin
        if (grant_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_ADD;
      vj_q  <= '0;
      qj_q  <= '0;
      vk_q  <= '0;
      qk_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (pay_en) begin
        op_q <= op_d;
        vj_q <= vj_d;
        qj_q <= qj_d;
        vk_q <= vk_d;
        qk_q <= qk_d;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_SUB:  result_o = vj_q - vk_q;
      OP_MUL:  result_o = vj_q * vk_q;
      OP_DIV:  result_o = (vk_q == '0) ? '1 : vj_q / vk_q;
      default: result_o = vj_q + vk_q;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = (st_q == ST_DONE);
endmodule

// File: rtl/rsv_regstat.sv
module rsv_regstat #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int NREG   = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_en_i,
  input  logic [AW-1:0]     iss_dst_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic [AW-1:0]     src1_i,
  input  logic [AW-1:0]     src2_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic [DATA_W-1:0] src1_v_o,
  output logic [TAG_W-1:0]  src1_q_o,
  output logic [DATA_W-1:0] src2_v_o,
  output logic [TAG_W-1:0]  src2_q_o,
  input  logic [AW-1:0]     obs_sel_i,
  output logic [DATA_W-1:0] obs_val_o,
  output logic [TAG_W-1:0]  obs_tag_o
);
  logic [DATA_W-1:0] val_arr  [NREG];
  logic [TAG_W-1:0]  stat_arr [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] v_q;
    logic [TAG_W-1:0]  s_q, s_d;
    logic              hit, claim;

    assign hit   = cdb_valid_i && (s_q != '0) && (s_q == cdb_tag_i);
    assign claim = iss_en_i && (iss_dst_i == AW'(r));

    always_comb begin
      s_d = s_q;
      if (claim)    s_d = iss_tag_i;
      else if (hit) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= DATA_W'(r);
        s_q <= '0;
      end else begin
        if (hit) v_q <= cdb_data_i;
        if (claim || hit) s_q <= s_d;
      end
    end

    assign val_arr[r]  = v_q;
    assign stat_arr[r] = s_q;
  end

  function automatic void lookup(input logic [AW-1:0] sel,
                                 output logic [DATA_W-1:0] v,
                                 output logic [TAG_W-1:0] q);
    logic [TAG_W-1:0] t;
    t = stat_arr[sel];
    if (t == '0) begin
      v = val_arr[sel];
      q = '0;
    end else if (cdb_valid_i && cdb_tag_i == t) begin
      v = cdb_data_i;
      q = '0;
    end else begin
      v = '0;
      q = t;
    end
  endfunction

  always_comb begin
    lookup(src1_i, src1_v_o, src1_q_o);
    lookup(src2_i, src2_v_o, src2_q_o);
  end

  assign obs_val_o = val_arr[obs_sel_i];
  assign obs_tag_o = stat_arr[obs_sel_i];
endmodule

// File: rtl/rsv_cdb_arb.sv
module rsv_cdb_arb #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      grant_o[i] = valid_o && (idx_o == IDX_W'(i));
    end
  end
endmodule

// File: rtl/rsv_core.sv
module rsv_core
  import rsv_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter int NREG    = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [1:0]              iss_op,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [$clog2(NREG)-1:0] iss_src1,
  input  logic [$clog2(NREG)-1:0] iss_src2,
  output logic                    iss_ready,
  output logic                    cdb_valid,
  output logic [TAG_W-1:0]        cdb_tag,
  output logic [DATA_W-1:0]       cdb_data,
  input  logic [$clog2(NREG)-1:0] obs_reg,
  output logic [DATA_W-1:0]       obs_value,
  output logic [TAG_W-1:0]        obs_tag
);
  // Station count must stay below 2**TAG_W so that tag 0 stays free.
  localparam int N       = N_ADD + N_MUL;
  localparam int IDX_W   = $clog2(N);
  localparam int AW      = $clog2(NREG);
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                               : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [N-1:0]      busy_vec, req_vec, grant_vec, alloc_vec;
  logic [DATA_W-1:0] res_arr [N];
  logic              add_ok, mul_ok, iss_fire;
  logic [IDX_W-1:0]  add_idx, mul_idx, pick_idx, arb_idx;
  logic [TAG_W-1:0]  iss_tag;
  logic [DATA_W-1:0] s1_v, s2_v;
  logic [TAG_W-1:0]  s1_q, s2_q;
  rsv_op_e           iss_op_e;

  assign iss_op_e = rsv_op_e'(iss_op);

  // Lowest free station in each class.
  always_comb begin
    add_ok  = 1'b0;
    add_idx = '0;
    for (int i = N_ADD - 1; i >= 0; i--) begin
      if (!busy_vec[i]) begin
        add_ok  = 1'b1;
        add_idx = IDX_W'(i);
      end
    end
    mul_ok  = 1'b0;
    mul_idx = '0;
    for (int i = N - 1; i >= N_ADD; i--) begin
      if (!busy_vec[i]) begin
        mul_ok  = 1'b1;
        mul_idx = IDX_W'(i);
      end
    end
  end

  assign iss_ready = iss_op[1] ? mul_ok : add_ok;
  assign pick_idx  = iss_op[1] ? mul_idx : add_idx;
  assign iss_fire  = iss_valid && iss_ready;
  assign iss_tag   = TAG_W'(pick_idx) + TAG_W'(1);

  rsv_cdb_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
    .req_i   (req_vec),
    .valid_o (cdb_valid),
    .idx_o   (arb_idx),
    .grant_o (grant_vec)
  );

  assign cdb_tag  = cdb_valid ? (TAG_W'(arb_idx) + TAG_W'(1)) : '0;
  assign cdb_data = cdb_valid ? res_arr[arb_idx] : '0;

  rsv_regstat #(.DATA_W(DATA_W), .TAG_W(TAG_W), .NREG(NREG), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_en_i    (iss_fire),
    .iss_dst_i   (iss_dst),
    .iss_tag_i   (iss_tag),
    .src1_i      (iss_src1),
    .src2_i      (iss_src2),
    .cdb_valid_i (cdb_valid),
    .cdb_tag_i   (cdb_tag),
    .cdb_data_i  (cdb_data),
    .src1_v_o    (s1_v),
    .src1_q_o    (s1_q),
    .src2_v_o    (s2_v),
    .src2_q_o    (s2_q),
    .obs_sel_i   (obs_reg),
    .obs_val_o   (obs_value),
    .obs_tag_o   (obs_tag)
  );

  for (genvar g = 0; g < N; g++) begin : g_rs
    assign alloc_vec[g] = iss_fire && (pick_idx == IDX_W'(g));

    rsv_station #(
      .DATA_W (DATA_W), .TAG_W (TAG_W), .CNT_W (CNT_W),
      .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_rs (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_vec[g]),
      .op_i        (iss_op_e),
      .vj_i        (s1_v),
      .qj_i        (s1_q),
      .vk_i        (s2_v),
      .qk_i        (s2_q),
      .cdb_valid_i (cdb_valid),
      .cdb_tag_i   (cdb_tag),
      .cdb_data_i  (cdb_data),
      .grant_i     (grant_vec[g]),
      .busy_o      (busy_vec[g]),
      .req_o       (req_vec[g]),
      .result_o    (res_arr[g])
    );
  end
endmodule

// File: rtl/rsv_core_chk.sv
module rsv_core_chk #(
  parameter int N     = 5,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic [N-1:0]     busy_vec,
  input logic [N-1:0]     req_vec,
  input logic [N-1:0]     grant_vec
);
  function automatic logic [N-1:0] lower_mask(input logic [TAG_W-1:0] t);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (TAG_W'(i + 1) < t);
    return m;
  endfunction

  function automatic logic bit_at(input logic [N-1:0] v, input logic [TAG_W-1:0] t);
    logic b;
    b = 1'b0;
    for (int i = 0; i < N; i++) if (t == TAG_W'(i + 1)) b = v[i];
    return b;
  endfunction

  a_r3_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag != '0) && (cdb_tag <= TAG_W'(N)));

  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> ((req_vec & lower_mask(cdb_tag)) == '0) && bit_at(req_vec, cdb_tag));

  a_r10_bus_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vec) |-> cdb_valid);

  a_r9_station_freed: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> !bit_at(busy_vec, $past(cdb_tag)));

  a_r2_stall_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && iss_ready) |=> $countones(busy_vec) <= $countones($past(busy_vec)));

  a_r2_issue_fills_one: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !cdb_valid) |=>
      $countones(busy_vec) == $countones($past(busy_vec)) + 1);

  for (genvar i = 0; i < N; i++) begin : g_hold
    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec[i] && !grant_vec[i]) |=> req_vec[i]);
  end
endmodule

bind rsv_core rsv_core_chk #(.N(N), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .cdb_valid (cdb_valid),
  .cdb_tag   (cdb_tag),
  .busy_vec  (busy_vec),
  .req_vec   (req_vec),
  .grant_vec (grant_vec)
);

// File: tb/rsv_core_test.sv
`timescale 1ns/1ps
module rsv_core_test;
  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2, DIV = 2'd3;

  logic        clk, rst_n, iss_valid, iss_ready, cdb_valid;
  logic [1:0]  iss_op;
  logic [2:0]  iss_dst, iss_src1, iss_src2, obs_reg;
  logic [3:0]  cdb_tag, obs_tag;
  logic [63:0] cdb_data, obs_value;
  int          cyc = 0, checks = 0, errors = 0;

  rsv_core uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .obs_reg(obs_reg), .obs_value(obs_value),
    .obs_tag(obs_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Drive one instruction and hold it across the next rising edge.
  task automatic issue(input logic [1:0] op, input logic [2:0] d, s1, s2, output int k);
    iss_op = op; iss_dst = d; iss_src1 = s1; iss_src2 = s2; iss_valid = 1'b1;
    #1 chk("R2 ready before issue", 64'(iss_ready), 64'd1);
    @(posedge clk);
    #1 k = cyc;
    iss_valid = 1'b0;
  endtask

  task automatic wait_cdb(input logic [3:0] t, output int at, output logic [63:0] d);
    int n = 0;
    at = -1; d = '0;
    while (n < 200) begin
      @(negedge clk);
      if (cdb_valid && cdb_tag == t) begin at = cyc; d = cdb_data; break; end
      n++;
    end
    if (at < 0) chk("R10 broadcast timeout tag", 64'(t), 64'hFFFF);
  endtask

  task automatic look(input logic [2:0] r, output logic [63:0] v, output logic [3:0] t);
    obs_reg = r;
    #1 v = obs_value; t = obs_tag;
  endtask

  task automatic t_reset();
    logic [63:0] v; logic [3:0] t;
    @(negedge clk);
    chk("R1 no broadcast", 64'(cdb_valid), 64'd0);
    for (int r = 0; r < 8; r++) begin
      look(3'(r), v, t);
      chk("R1 reg value", v, 64'(r));
      chk("R1 reg tag", 64'(t), 64'd0);
    end
    iss_op = ADD; #1 chk("R1 add ready", 64'(iss_ready), 64'd1);
    iss_op = MUL; #1 chk("R1 mul ready", 64'(iss_ready), 64'd1);
  endtask

  task automatic t_add_sub();
    int k, at; logic [63:0] d, v; logic [3:0] t;
    @(negedge clk); issue(ADD, 3'd5, 3'd3, 3'd4, k);
    look(3'd5, v, t); chk("R5 dst tag after add issue", 64'(t), 64'd1);
    wait_cdb(4'd1, at, d);
    chk("R6 add latency", 64'(at - k), 64'd4);
    chk("R7 add result", d, 64'd7);
    @(negedge clk); look(3'd5, v, t);
    chk("R9 reg written", v, 64'd7);
    chk("R9 status cleared", 64'(t), 64'd0);
    issue(SUB, 3'd6, 3'd3, 3'd2, k);
    look(3'd6, v, t); chk("R3 freed station reused tag", 64'(t), 64'd1);
    wait_cdb(4'd1, at, d);
    chk("R6 sub latency", 64'(at - k), 64'd4);
    chk("R13 sub order 3-2", d, 64'd1);
    @(negedge clk);
  endtask

  task automatic t_mul_div();
    int k, at; logic [63:0] d, v; logic [3:0] t;
    issue(MUL, 3'd7, 3'd3, 3'd4, k);
    look(3'd7, v, t); chk("R3 first mul tag", 64'(t), 64'd4);
    wait_cdb(4'd4, at, d);
    chk("R6 mul latency", 64'(at - k), 64'd11);
    chk("R7 mul result", d, 64'd12);
    @(negedge clk); issue(DIV, 3'd6, 3'd4, 3'd2, k);
    wait_cdb(4'd4, at, d);
    chk("R6 div latency", 64'(at - k), 64'd41);
    chk("R13 div order 4/2", d, 64'd2);
    @(negedge clk); issue(DIV, 3'd7, 3'd4, 3'd0, k);
    wait_cdb(4'd4, at, d);
    chk("R7 divide by zero", d, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); look(3'd7, v, t);
    chk("R9 div result written", v, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_dependency();
    int k1, k2, p, c; logic [63:0] d, v; logic [3:0] t;
    @(negedge clk); issue(MUL, 3'd5, 3'd3, 3'd4, k1);
    issue(ADD, 3'd6, 3'd5, 3'd1, k2);
    look(3'd5, v, t); chk("R4 source pending tag", 64'(t), 64'd4);
    wait_cdb(4'd4, p, d);
    chk("R6 producer latency", 64'(p - k1), 64'd11);
    wait_cdb(4'd1, c, d);
    chk("R8 consumer after producer", 64'(c - p), 64'd5);
    chk("R8 consumer result", d, 64'd13);
    @(negedge clk); look(3'd6, v, t);
    chk("R8 consumer reg", v, 64'd13);
  endtask

  task automatic t_structural();
    int k, at; logic [63:0] d, v; logic [3:0] t;
    @(negedge clk);
    issue(ADD, 3'd5, 3'd1, 3'd1, k);
    issue(ADD, 3'd6, 3'd1, 3'd2, k);
    issue(ADD, 3'd7, 3'd2, 3'd2, k);
    look(3'd7, v, t); chk("R3 third add tag", 64'(t), 64'd3);
    iss_op = ADD; #1 chk("R2 add class full stalls", 64'(iss_ready), 64'd0);
    iss_op = MUL; #1 chk("R2 mul class still free", 64'(iss_ready), 64'd1);
    wait_cdb(4'd1, at, d); chk("R10 tag1 data", d, 64'd2);
    wait_cdb(4'd2, at, d); chk("R10 tag2 data", d, 64'd3);
    wait_cdb(4'd3, at, d); chk("R10 tag3 data", d, 64'd4);
    @(negedge clk);
  endtask

  task automatic t_collision();
    int k, p, a, b; logic [63:0] d;
    issue(MUL, 3'd5, 3'd1, 3'd4, k);
    issue(ADD, 3'd6, 3'd5, 3'd1, k);
    issue(ADD, 3'd7, 3'd5, 3'd2, k);
    wait_cdb(4'd4, p, d); chk("R7 mul 1*4", d, 64'd4);
    wait_cdb(4'd1, a, d);
    chk("R10 lowest tag first", 64'(a - p), 64'd5);
    chk("R8 first consumer data", d, 64'd5);
    wait_cdb(4'd2, b, d);
    chk("R10 loser one cycle later", 64'(b - a), 64'd1);
    chk("R10 held result", d, 64'd6);
    @(negedge clk);
  endtask

  task automatic t_bypass();
    int k, at; logic [63:0] d, v; logic [3:0] t;
    issue(ADD, 3'd5, 3'd1, 3'd2, k);
    wait_cdb(4'd1, at, d);
    issue(ADD, 3'd6, 3'd5, 3'd5, k);
    look(3'd5, v, t);
    chk("R9 producer reg", v, 64'd3);
    look(3'd6, v, t); chk("R11 consumer tag", 64'(t), 64'd2);
    wait_cdb(4'd2, at, d);
    chk("R11 bypass latency", 64'(at - k), 64'd4);
    chk("R11 bypass result", d, 64'd6);
    @(negedge clk);
  endtask

  task automatic t_waw();
    int k, at; logic [63:0] d, v; logic [3:0] t;
    issue(MUL, 3'd7, 3'd2, 3'd4, k);
    issue(ADD, 3'd7, 3'd1, 3'd1, k);
    look(3'd7, v, t); chk("R12 newer writer owns status", 64'(t), 64'd1);
    wait_cdb(4'd1, at, d);
    @(negedge clk); look(3'd7, v, t);
    chk("R12 newer value", v, 64'd2);
    wait_cdb(4'd4, at, d); chk("R7 stale mul data", d, 64'd8);
    @(negedge clk); look(3'd7, v, t);
    chk("R12 stale write ignored", v, 64'd2);
    chk("R12 status stays blank", 64'(t), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = ADD;
    iss_dst = '0; iss_src1 = '0; iss_src2 = '0; obs_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_add_sub();
    t_mul_div();
    t_dependency();
    t_structural();
    t_collision();
    t_bypass();
    t_waw();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule